// File: doc/BRIEF.md
# Range-Based Access Permission Checker

This block decides, for every data read, data write or instruction fetch, whether the address may be touched. It keeps a shared pool of 16 data address windows and 8 code address windows. Each window has a lower bound, which is inclusive, and an upper bound, which is exclusive. Both bounds are 32-bit values aligned to 8 bytes.

Four permission sets sit on top of the pool. For every data window, a set holds a read bit and a write bit. For every code window, a set holds an execute bit. Clearing all of a window's bits in a set leaves that window out of the set. Any window can therefore serve any set. Exactly one set is active at a time, so switching a task's permissions takes a single register write.

A small write-only register port loads the bounds, the per-set masks and the active set number. Each request produces a registered answer one cycle later. A denied request also raises a one-cycle violation flag, which carries the access type and the faulting address.

Top module: `mpc_prot_check`

## Requirements
- R1: After reset every bound and every mask is zero and the active set is 0, so every access is denied.
- R2: An address hits a window when lower <= address < upper. Bits [2:0] of a written bound are stored as zero.
- R3: A read (type 0) is allowed when at least one data window that it hits has its read bit set in the active set's read mask.
- R4: A write (type 1) is allowed when at least one data window that it hits has its write bit set in the active set's write mask.
- R5: A fetch (type 2) is checked only against code windows and execute masks. Data windows never grant a fetch, and code windows never grant a read or a write. Type 3 is always denied.
- R6: A request with req_valid high yields resp_valid high on the next cycle. In that cycle resp_allow holds the decision.
- R7: A denied request raises viol for exactly that response cycle. In the same cycle, viol_type and viol_addr equal the request's type and address. An allowed request leaves viol low.
- R8: A write to the active-set register applies to requests presented on the cycle after the write. A request presented in the same cycle as the write is judged by the old set.
- R9: When windows overlap, one granting window is enough. A window without the needed bit does not block the grant.
- R10: With req_valid low, resp_valid and viol are low on the next cycle.
- R11: Register map, by word address on cfg_addr:
  - 0x00–0x1F: data bounds. Bit 0 selects lower (0) or upper (1), and bits [4:1] give the window index.
  - 0x20–0x2F: code bounds, with the same bit 0 meaning and bits [3:1] giving the index.
  - 0x30+s, 0x34+s, 0x38+s: the read, write and execute masks of set s.
  - 0x3C: the active set, taken from cfg_wdata[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request present |
| req_type | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_addr | input | 32 | Access address |
| resp_valid | output | 1 | Decision present (one cycle after the request) |
| resp_allow | output | 1 | Access permitted |
| viol | output | 1 | One-cycle violation flag |
| viol_type | output | 2 | Type of the judged request |
| viol_addr | output | 32 | Address of the judged request |

## Verification
A corrupted bound shows up as a wrong allow or deny at a window edge on the very next response. For that reason every window is probed one below its lower bound, at the lower bound, one below its upper bound, and at the upper bound. A mask bit stuck in one set only shows up while that set is active, so the sweep repeats over all four sets, and a fault appears within the first pass over the affected window. An active-set register that updates a cycle early or late changes the answer to the request presented alongside the write, or to the request that follows it.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int AW = 32;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  function automatic logic [AW-1:0] align8(input logic [AW-1:0] v);
    return {v[AW-1:3], 3'b000};
  endfunction

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction
endpackage

// File: rtl/mpc_window_match.sv
module mpc_window_match
  import mpc_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo [N],
  input  logic [AW-1:0] hi [N],
  output logic [N-1:0]  hit
);
  for (genvar i = 0; i < N; i++) begin : g_win
    assign hit[i] = in_window(addr, lo[i], hi[i]);
  end
endmodule

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
  import mpc_pkg::*;
#(
  parameter int N_DATA = 16,
  parameter int N_CODE = 8,
  parameter int N_SETS = 4,
  parameter int CAW    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CAW-1:0]        cfg_addr,
  input  logic [AW-1:0]         cfg_wdata,
  output logic [AW-1:0]         d_lo [N_DATA],
  output logic [AW-1:0]         d_hi [N_DATA],
  output logic [AW-1:0]         c_lo [N_CODE],
  output logic [AW-1:0]         c_hi [N_CODE],
  output logic [N_DATA-1:0]     rd_mask [N_SETS],
  output logic [N_DATA-1:0]     wr_mask [N_SETS],
  output logic [N_CODE-1:0]     ex_mask [N_SETS],
  output logic [$clog2(N_SETS)-1:0] active_set
);
  localparam int DIW = $clog2(N_DATA);
  localparam int CIW = $clog2(N_CODE);
  localparam int SW  = $clog2(N_SETS);

  logic sel_data, sel_code, sel_misc;
  assign sel_data = cfg_we && (cfg_addr[CAW-1] == 1'b0);
  assign sel_code = cfg_we && (cfg_addr[CAW-1:CAW-2] == 2'b10);
  assign sel_misc = cfg_we && (cfg_addr[CAW-1:CAW-2] == 2'b11);

  for (genvar i = 0; i < N_DATA; i++) begin : g_dreg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d_lo[i] <= '0;
        d_hi[i] <= '0;
      end else if (sel_data && cfg_addr[DIW:1] == DIW'(i)) begin
        if (cfg_addr[0]) d_hi[i] <= align8(cfg_wdata);
        else             d_lo[i] <= align8(cfg_wdata);
      end
    end
  end

  for (genvar j = 0; j < N_CODE; j++) begin : g_creg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_lo[j] <= '0;
        c_hi[j] <= '0;
      end else if (sel_code && cfg_addr[CIW:1] == CIW'(j)) begin
        if (cfg_addr[0]) c_hi[j] <= align8(cfg_wdata);
        else             c_lo[j] <= align8(cfg_wdata);
      end
    end
  end

  for (genvar s = 0; s < N_SETS; s++) begin : g_sreg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_mask[s] <= '0;
        wr_mask[s] <= '0;
        ex_mask[s] <= '0;
      end else if (sel_misc && cfg_addr[SW-1:0] == SW'(s)) begin
        case (cfg_addr[3:2])
          2'b00:   rd_mask[s] <= cfg_wdata[N_DATA-1:0];
          2'b01:   wr_mask[s] <= cfg_wdata[N_DATA-1:0];
          2'b10:   ex_mask[s] <= cfg_wdata[N_CODE-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              active_set <= '0;
    else if (sel_misc && cfg_addr[3:2] == 2'b11) active_set <= cfg_wdata[SW-1:0];
  end
endmodule

// File: rtl/mpc_prot_check.sv
module mpc_prot_check
  import mpc_pkg::*;
#(
  parameter int N_DATA = 16,
  parameter int N_CODE = 8,
  parameter int N_SETS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic [1:0]    req_type,
  input  logic [31:0]   req_addr,
  output logic          resp_valid,
  output logic          resp_allow,
  output logic          viol,
  output logic [1:0]    viol_type,
  output logic [31:0]   viol_addr
);
  localparam int SW = $clog2(N_SETS);

  logic [AW-1:0]     d_lo [N_DATA];
  logic [AW-1:0]     d_hi [N_DATA];
  logic [AW-1:0]     c_lo [N_CODE];
  logic [AW-1:0]     c_hi [N_CODE];
  logic [N_DATA-1:0] rd_mask [N_SETS];
  logic [N_DATA-1:0] wr_mask [N_SETS];
  logic [N_CODE-1:0] ex_mask [N_SETS];
  logic [SW-1:0]     active_set;

  mpc_cfg_regs #(.N_DATA(N_DATA), .N_CODE(N_CODE), .N_SETS(N_SETS), .CAW(6)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .d_lo(d_lo), .d_hi(d_hi), .c_lo(c_lo), .c_hi(c_hi),
    .rd_mask(rd_mask), .wr_mask(wr_mask), .ex_mask(ex_mask),
    .active_set(active_set)
  );

  logic [N_DATA-1:0] data_hit;
  logic [N_CODE-1:0] code_hit;

  mpc_window_match #(.N(N_DATA)) u_dmatch (
    .addr(req_addr), .lo(d_lo), .hi(d_hi), .hit(data_hit));
  mpc_window_match #(.N(N_CODE)) u_cmatch (
    .addr(req_addr), .lo(c_lo), .hi(c_hi), .hit(code_hit));

  // Named internal events used by the checker
  logic data_hit_any, code_hit_any, grant_rd, grant_wr, grant_ex, grant;
  assign data_hit_any = |data_hit;
  assign code_hit_any = |code_hit;
  assign grant_rd     = |(data_hit & rd_mask[active_set]);
  assign grant_wr     = |(data_hit & wr_mask[active_set]);
  assign grant_ex     = |(code_hit & ex_mask[active_set]);

  always_comb begin
    case (acc_t'(req_type))
      ACC_READ:  grant = grant_rd;
      ACC_WRITE: grant = grant_wr;
      ACC_FETCH: grant = grant_ex;
      default:   grant = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      viol       <= 1'b0;
      viol_type  <= '0;
      viol_addr  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= req_valid && grant;
      viol       <= req_valid && !grant;
      if (req_valid) begin
        viol_type <= req_type;
        viol_addr <= req_addr;
      end
    end
  end
endmodule

module mpc_prot_check_sva #(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [5:0]    cfg_addr,
  input logic          req_valid,
  input logic [1:0]    req_type,
  input logic [31:0]   req_addr,
  input logic          resp_valid,
  input logic          resp_allow,
  input logic          viol,
  input logic [1:0]    viol_type,
  input logic [31:0]   viol_addr,
  input logic          data_hit_any,
  input logic          code_hit_any,
  input logic [SW-1:0] active_set
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !viol)); // R10
  AST_VIOL_MEANS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (resp_valid && !resp_allow)); // R7
  AST_VIOL_CARRIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (viol_addr == $past(req_addr) && viol_type == $past(req_type))); // R7
  AST_DATA_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type != 2'd2 && !data_hit_any) |=> !resp_allow); // R3
  AST_FETCH_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd2 && !code_hit_any) |=> !resp_allow); // R5
  AST_RSVD_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd3) |=> viol); // R5
  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr[5:2] == 4'hF) |=> $stable(active_set)); // R8
endmodule

bind mpc_prot_check mpc_prot_check_sva #(.SW(SW)) u_sva (.*);

// File: tb/mpc_prot_check_tb.sv
module mpc_prot_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [31:0] req_addr = '0;
  logic        resp_valid, resp_allow, viol;
  logic [1:0]  viol_type;
  logic [31:0] viol_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mpc_prot_check u_dut (.*);

  // Bench-side model of programmed state
  logic [31:0] m_dlo [16];
  logic [31:0] m_dhi [16];
  logic [31:0] m_clo [8];
  logic [31:0] m_chi [8];
  logic [15:0] m_rd [4];
  logic [15:0] m_wr [4];
  logic [7:0]  m_ex [4];
  int          m_set;

  function automatic bit model_allow(input int t, input logic [31:0] a);
    bit ok = 1'b0;
    if (t == 2) begin
      for (int j = 0; j < 8; j++)
        if (a >= m_clo[j] && a < m_chi[j] && m_ex[m_set][j]) ok = 1'b1;
    end else if (t < 2) begin
      for (int i = 0; i < 16; i++)
        if (a >= m_dlo[i] && a < m_dhi[i] &&
            ((t == 0) ? m_rd[m_set][i] : m_wr[m_set][i])) ok = 1'b1;
    end
    return ok;
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_bound(input bit code, input int idx, input bit upper,
                           input logic [31:0] v);
    wr_cfg(code ? 6'(32 + idx*2 + upper) : 6'(idx*2 + upper), v);
    if (code) begin
      if (upper) m_chi[idx] = {v[31:3], 3'b0}; else m_clo[idx] = {v[31:3], 3'b0};
    end else begin
      if (upper) m_dhi[idx] = {v[31:3], 3'b0}; else m_dlo[idx] = {v[31:3], 3'b0};
    end
  endtask

  task automatic access(input int t, input logic [31:0] a, input string req);
    bit exp;
    exp = model_allow(t, a);
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid === 1'b1, req, "resp_valid", 32'(resp_valid), 1);
    chk(resp_allow === exp, req, $sformatf("allow t=%0d a=%h", t, a), 32'(resp_allow), 32'(exp));
    chk(viol === !exp, req, "viol", 32'(viol), 32'(!exp));
    if (!exp) begin
      chk(viol_addr === a, "R7", "viol_addr", viol_addr, a);
      chk(viol_type === 2'(t), "R7", "viol_type", 32'(viol_type), 32'(t));
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_dlo[i] = 0; m_dhi[i] = 0; end
    for (int j = 0; j < 8; j++)  begin m_clo[j] = 0; m_chi[j] = 0; end
    for (int s = 0; s < 4; s++)  begin m_rd[s] = 0; m_wr[s] = 0; m_ex[s] = 0; end
    m_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(resp_valid === 1'b0 && viol === 1'b0, "R1", "reset outputs",
        {30'b0, resp_valid, viol}, 0);
    // R1: everything denied after reset
    access(0, 32'h0, "R1");
    access(1, 32'h0000_1000, "R1");
    access(2, 32'h0, "R1");

    // R10: idle cycle yields no response
    @(negedge clk);
    chk(resp_valid === 1'b0 && viol === 1'b0, "R10", "idle", {30'b0, resp_valid, viol}, 0);

    // Program windows and masks, computed arithmetically (R11 map)
    for (int i = 0; i < 16; i++) begin
      set_bound(0, i, 0, 32'h1000 + i*32'h100);
      set_bound(0, i, 1, 32'h1080 + i*32'h100);
    end
    for (int j = 0; j < 8; j++) begin
      set_bound(1, j, 0, 32'h8000 + j*32'h200);
      set_bound(1, j, 1, 32'h8108 + j*32'h200);
    end
    for (int s = 0; s < 4; s++) begin
      m_rd[s] = 16'h5A3C ^ (16'h1111 << s);
      m_wr[s] = ~m_rd[s] ^ (16'h0F0F >> s);
      m_ex[s] = 8'h96 ^ (8'h3 << (2*s));
      wr_cfg(6'(48 + s), {16'b0, m_rd[s]});
      wr_cfg(6'(52 + s), {16'b0, m_wr[s]});
      wr_cfg(6'(56 + s), {24'b0, m_ex[s]});
    end

    // Sweep all sets, windows, edges (R2 R3 R4 R5)
    for (int s = 0; s < 4; s++) begin
      wr_cfg(6'h3C, 32'(s)); m_set = s;
      for (int i = 0; i < 16; i++) begin
        logic [31:0] lo, hi;
        lo = m_dlo[i]; hi = m_dhi[i];
        access(0, lo - 1, "R2"); access(0, lo, "R3"); access(0, hi - 1, "R3"); access(0, hi, "R2");
        access(1, lo - 1, "R2"); access(1, lo, "R4"); access(1, hi - 1, "R4"); access(1, hi, "R2");
        access(2, lo, "R5");
      end
      for (int j = 0; j < 8; j++) begin
        logic [31:0] lo, hi;
        lo = m_clo[j]; hi = m_chi[j];
        access(2, lo - 1, "R2"); access(2, lo, "R5"); access(2, hi - 1, "R5"); access(2, hi, "R2");
        access(0, lo, "R5"); access(1, hi - 1, "R5");
      end
      access(3, m_dlo[0], "R5");
      access(3, m_clo[0], "R5");
    end

    // R2: low bits of a bound are dropped
    set_bound(0, 0, 0, 32'h0000_1003);
    set_bound(0, 0, 1, 32'h0000_1087);
    wr_cfg(6'h33, 32'h0001); m_rd[3] = 16'h0001;
    access(0, 32'h0000_1000, "R2");
    access(0, 32'h0000_107F, "R2");
    access(0, 32'h0000_1080, "R2");

    // R9: overlapping windows, one grants
    set_bound(0, 0, 1, 32'h0000_1200);
    wr_cfg(6'h33, 32'h0001); m_rd[3] = 16'h0001;  // window 1 lacks read, window 0 grants
    access(0, 32'h0000_1100, "R9");
    wr_cfg(6'h33, 32'h0002); m_rd[3] = 16'h0002;  // window 0 lacks read, window 1 grants
    access(0, 32'h0000_1100, "R9");
    access(0, 32'h0000_1190, "R9");

    // R8: same-cycle request uses old set, next one uses new
    wr_cfg(6'h30, 32'h0001); m_rd[0] = 16'h0001;
    wr_cfg(6'h31, 32'h0000); m_rd[1] = 16'h0000;
    wr_cfg(6'h3C, 32'h0);    m_set = 0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'h3C; cfg_wdata = 32'h1;
    req_valid = 1'b1; req_type = 2'd0; req_addr = 32'h0000_1000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(resp_allow === 1'b1, "R8", "same-cycle old set", 32'(resp_allow), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_allow === 1'b0 && viol === 1'b1, "R8", "next-cycle new set",
        {30'b0, resp_allow, viol}, 1);
    @(negedge clk);
    chk(viol === 1'b0, "R7", "viol single cycle", 32'(viol), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule